// File: doc/BRIEF.md
# ALU Five-Tick Operation Sequencer

This block steps one ALU operation through a fixed run of five clock ticks. It drives the individual strobes that the surrounding datapath needs. It does not decode instructions, select register-file operands or perform any arithmetic. It takes a start request and a binary index of the operation class, which names the function unit (adder, subtractor, the logic units, the shifter). It then issues, in order: a result-register clear/load, operand enables, a compute strobe with a one-hot function-unit select, an idle settle tick, a clear of the destination register and carry storage, and finally the strobe that puts the result register onto the data bus. A one-cycle done pulse marks the final tick.

The sequence has six named states. PH_IDLE waits for a request. PH_CLR is tick 1, PH_EVAL is tick 2, PH_SETTLE is tick 3, PH_DCLR is tick 4 and PH_DRIVE is tick 5. The transitions are named as follows. GO goes from PH_IDLE to PH_CLR when start is sampled high in idle. ADV steps each tick to the next one, one per clock. FIN goes from PH_DRIVE back to PH_IDLE. Every strobe is a Moore output of the current state. The class index is captured on GO and held until the run ends. A synchronous reset returns the machine to PH_IDLE from any state.

Top module: `alu_tick_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the block enters PH_IDLE. In the cycle after that edge every output is 0, and `start_i` is ignored during reset.
- R2: When `start_i` is 1 at an edge in PH_IDLE, the following cycle is tick 1. In tick 1, `res_ld_o`, `opa_en_o` and `opb_en_o` are 1 and every other output is 0.
- R3: Tick 2 follows tick 1. In tick 2, `alu_sel_o`, `opa_en_o` and `opb_en_o` are 1 and `res_ld_o` is 0. `unit_sel_o` has only bit k set, where k is the class index captured on GO.
- R4: Tick 3 follows tick 2 and is a settle tick in which every output is 0.
- R5: Tick 4 follows tick 3. Only `dst_ld_o` is 1 in tick 4.
- R6: Tick 5 follows tick 4. Only `res_sel_o` and `done_o` are 1 in tick 5.
- R7: After tick 5 the block is in PH_IDLE for at least one cycle with all outputs 0. `done_o` is high for exactly one cycle per operation.
- R8: A high `start_i` in ticks 1 to 5 is ignored. A change of `op_cls_i` after GO does not alter `unit_sel_o` for that operation.
- R9: A class index of NUM_CLS or above still runs all five ticks, but `unit_sel_o` stays all zero.
- R10: `dst_ld_o` is only ever high in a cycle whose previous cycle had `alu_sel_o` low. `dst_ld_o` is never high together with `res_ld_o` or `alu_sel_o`.
- R11: With `start_i` held high, a new operation starts every six cycles: five ticks, then one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin an operation, sampled in idle only |
| op_cls_i | input | CLS_W | Binary index of the function unit, captured on GO |
| res_ld_o | output | 1 | Clear/load strobe of the result register (tick 1) |
| opa_en_o | output | 1 | First operand enable (ticks 1 and 2) |
| opb_en_o | output | 1 | Second operand enable (ticks 1 and 2) |
| alu_sel_o | output | 1 | Compute strobe that captures the result (tick 2) |
| unit_sel_o | output | NUM_CLS | One-hot function-unit select (tick 2) |
| dst_ld_o | output | 1 | Destination register and carry storage clear/load (tick 4) |
| res_sel_o | output | 1 | Result register onto data bus 1, carry storage update (tick 5) |
| done_o | output | 1 | One-cycle completion pulse (tick 5) |

## Verification
The bench holds `start_i` high through whole runs and changes `op_cls_i` in the middle of a run. A design that restarted while busy, or that followed the live class input, would shorten the sequence or move the unit select. An out-of-range class index is issued to catch a decoder that wraps it onto a real unit. A reset pulse in the middle of a run, and a request held high through reset, check that no strobe leaks out of a cut-off run. The back-to-back runs check that exactly one idle cycle separates operations and that the destination load never comes directly after the compute strobe.

// File: rtl/alu_seq_pkg.sv
package alu_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_CLR    = 3'd1,
        PH_EVAL   = 3'd2,
        PH_SETTLE = 3'd3,
        PH_DCLR   = 3'd4,
        PH_DRIVE  = 3'd5
    } phase_t;

endpackage

// File: rtl/alu_seq_ctrl.sv
module alu_seq_ctrl
    import alu_seq_pkg::*;
#(
    parameter int CLS_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CLS_W-1:0] cls_i,
    output phase_t           phase_o,
    output logic [CLS_W-1:0] cls_o
);

    phase_t           phase_q;
    phase_t           phase_d;
    logic [CLS_W-1:0] cls_q;
    logic             go;

    assign go = (phase_q == PH_IDLE) && start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q <= '0;
        end else if (go) begin
            cls_q <= cls_i;
        end
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   phase_d = go ? PH_CLR : PH_IDLE;
            PH_CLR:    phase_d = PH_EVAL;
            PH_EVAL:   phase_d = PH_SETTLE;
            PH_SETTLE: phase_d = PH_DCLR;
            PH_DCLR:   phase_d = PH_DRIVE;
            PH_DRIVE:  phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    assign phase_o = phase_q;
    assign cls_o   = cls_q;

    // R8
    go_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CLR) |-> ($past(phase_q) == PH_IDLE));

    // R7
    drive_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DRIVE) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/alu_seq_unitdec.sv
module alu_seq_unitdec #(
    parameter int NUM_CLS = 6,
    parameter int CLS_W   = 3
) (
    input  logic               en_i,
    input  logic [CLS_W-1:0]   cls_i,
    output logic [NUM_CLS-1:0] sel_o
);

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_unit
        assign sel_o[g] = en_i && (cls_i == CLS_W'(g));
    end

    // R3
    unit_onehot_chk: assert final ($onehot0(sel_o));

endmodule

// File: rtl/alu_seq_strobe.sv
module alu_seq_strobe
    import alu_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase_i,
    output logic   res_ld_o,
    output logic   opa_en_o,
    output logic   opb_en_o,
    output logic   alu_sel_o,
    output logic   dst_ld_o,
    output logic   res_sel_o,
    output logic   done_o
);

    always_comb begin
        res_ld_o  = 1'b0;
        opa_en_o  = 1'b0;
        opb_en_o  = 1'b0;
        alu_sel_o = 1'b0;
        dst_ld_o  = 1'b0;
        res_sel_o = 1'b0;
        done_o    = 1'b0;
        unique case (phase_i)
            PH_IDLE: ;
            PH_CLR: begin
                res_ld_o = 1'b1;
                opa_en_o = 1'b1;
                opb_en_o = 1'b1;
            end
            PH_EVAL: begin
                alu_sel_o = 1'b1;
                opa_en_o  = 1'b1;
                opb_en_o  = 1'b1;
            end
            PH_SETTLE: ;
            PH_DCLR:   dst_ld_o = 1'b1;
            PH_DRIVE: begin
                res_sel_o = 1'b1;
                done_o    = 1'b1;
            end
            default: ;
        endcase
    end

    // R10
    dst_after_settle_chk: assert property (@(posedge clk) disable iff (rst)
        dst_ld_o |-> ($past(!alu_sel_o) && !res_ld_o && !alu_sel_o));

endmodule

// File: rtl/alu_tick_seq.sv
module alu_tick_seq
    import alu_seq_pkg::*;
#(
    parameter  int NUM_CLS = 6,
    localparam int CLS_W   = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [CLS_W-1:0]   op_cls_i,
    output logic               res_ld_o,
    output logic               opa_en_o,
    output logic               opb_en_o,
    output logic               alu_sel_o,
    output logic [NUM_CLS-1:0] unit_sel_o,
    output logic               dst_ld_o,
    output logic               res_sel_o,
    output logic               done_o
);

    phase_t           phase;
    logic [CLS_W-1:0] cls_hold;

    alu_seq_ctrl #(.CLS_W(CLS_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cls_i   (op_cls_i),
        .phase_o (phase),
        .cls_o   (cls_hold)
    );

    alu_seq_strobe u_strobe (
        .clk       (clk),
        .rst       (rst),
        .phase_i   (phase),
        .res_ld_o  (res_ld_o),
        .opa_en_o  (opa_en_o),
        .opb_en_o  (opb_en_o),
        .alu_sel_o (alu_sel_o),
        .dst_ld_o  (dst_ld_o),
        .res_sel_o (res_sel_o),
        .done_o    (done_o)
    );

    alu_seq_unitdec #(.NUM_CLS(NUM_CLS), .CLS_W(CLS_W)) u_unitdec (
        .en_i  (alu_sel_o),
        .cls_i (cls_hold),
        .sel_o (unit_sel_o)
    );

    // R9
    unit_in_eval_chk: assert property (@(posedge clk) disable iff (rst)
        (|unit_sel_o) |-> alu_sel_o);

    // R3
    eval_after_clr_chk: assert property (@(posedge clk) disable iff (rst)
        alu_sel_o |-> $past(res_ld_o));

    // R6
    done_with_drive_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (res_sel_o && !dst_ld_o));

endmodule

// File: tb/alu_tick_seq_tb.sv
`timescale 1ns/1ps
module alu_tick_seq_tb;

    localparam int NUM_CLS = 6;
    localparam int CLS_W   = 3;
    localparam int OW      = 7 + NUM_CLS;

    logic               clk = 1'b0;
    logic               rst;
    logic               start;
    logic [CLS_W-1:0]   cls;
    logic               res_ld, opa_en, opb_en, alu_sel, dst_ld, res_sel, done;
    logic [NUM_CLS-1:0] unit_sel;

    int    total = 0;
    int    bad   = 0;
    int    cyc   = 0;
    int    m_tick = 0;
    int    m_cls  = 0;
    bit    armed  = 1'b0;
    string scen   = "R1 reset";

    always #2 clk = ~clk;

    alu_tick_seq #(.NUM_CLS(NUM_CLS)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .op_cls_i   (cls),
        .res_ld_o   (res_ld),
        .opa_en_o   (opa_en),
        .opb_en_o   (opb_en),
        .alu_sel_o  (alu_sel),
        .unit_sel_o (unit_sel),
        .dst_ld_o   (dst_ld),
        .res_sel_o  (res_sel),
        .done_o     (done)
    );

    // reference model: tick 0 = idle, 1..5 = ticks
    always @(posedge clk) begin
        armed = 1'b1;
        cyc++;
        if (rst) m_tick = 0;
        else if (m_tick == 0) begin
            if (start) begin
                m_tick = 1;
                m_cls  = int'(cls);
            end
        end else if (m_tick == 5) m_tick = 0;
        else m_tick++;
    end

    function automatic string tick_tag(int t);
        case (t)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(negedge clk) begin
        logic [OW-1:0]      exp_v;
        logic [OW-1:0]      act_v;
        logic [NUM_CLS-1:0] eu;
        if (armed) begin
            eu = '0;
            if (m_tick == 2 && m_cls < NUM_CLS) eu[m_cls] = 1'b1;
            exp_v = {m_tick == 1, m_tick == 1 || m_tick == 2, m_tick == 1 || m_tick == 2,
                     m_tick == 2, eu, m_tick == 4, m_tick == 5, m_tick == 5};
            act_v = {res_ld, opa_en, opb_en, alu_sel, unit_sel, dst_ld, res_sel, done};
            total++;
            if (act_v !== exp_v) begin
                bad++;
                $display("FAIL %s [%s] tick=%0d act=%b exp=%b",
                         tick_tag(m_tick), scen, m_tick, act_v, exp_v);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 5000) begin
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(logic [CLS_W-1:0] c, int after);
        cls   = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_n(after);
    endtask

    initial begin
        rst   = 1'b1;
        start = 1'b1;
        cls   = '0;
        scen  = "R1 start held in reset";
        wait_n(3);
        rst   = 1'b0;
        start = 1'b0;
        scen  = "R1 idle after reset";
        wait_n(3);

        scen = "R2 single op class 0";
        pulse(3'd0, 7);

        scen  = "R8 R11 start held, class changed mid-run";
        cls   = 3'd3;
        start = 1'b1;
        wait_n(2);
        cls   = 3'd4;
        wait_n(3);
        cls   = 3'd1;
        wait_n(8);
        start = 1'b0;
        wait_n(6);

        scen = "R9 class index 7";
        pulse(3'd7, 7);
        scen = "R9 class index 6";
        pulse(3'd6, 7);
        scen = "R10 class index 5";
        pulse(3'd5, 7);

        scen = "R1 reset mid-run";
        pulse(3'd2, 2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        wait_n(4);
        scen = "R7 op after reset";
        pulse(3'd2, 7);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule